// File: doc/BRIEF.md
# Configurable SPI Master Channel

This block is one SPI master channel. It sends a word out and takes a word in over a serial clock, one active-low chip select and two data pads. Either pad can be the master output, and the other pad is then the master input. Before each word the host sets these on configuration pins: clock idle level, clock phase, half-period length, chip-select guard length, word length and pad direction. It then hands over the transmit word with a valid/ready handshake. The block takes a snapshot of the configuration when it accepts the word. A transfer therefore always runs with one consistent setting, even if the configuration pins change while it runs.

The serial clock comes from the system clock. Each level lasts `cfg_half` system cycles, so the duty cycle is always 50% and the fastest serial clock is the system clock divided by two. Chip select asserts the cycle after acceptance. The first serial-clock edge follows after a guard of `cfg_tcs`+1 system cycles. With phase 0 the guard also includes one extra half period, because the first bit is already on the pad when chip select falls. Once the last edge has passed, chip select stays low for `cfg_tcs`+1 more cycles. The received word and a one-cycle `done` pulse appear together with the chip-select release.

Transmit back-pressure: `tx_ready` is high only while the channel is idle. A word is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_valid` has no effect while `tx_ready` is low. The receive side has no back-pressure: `rx_data` holds its value until the next `done`.

Top module: `spi_master_chan`

## Requirements
- R1: While no transfer runs, `sclk` equals `cfg_cpol`. During a transfer of N bits it toggles exactly 2N times, and consecutive toggles are `cfg_half` system cycles apart (`cfg_half` ≥ 1).
- R2: With phase 0 the input is captured on odd-numbered edges and the output changes on even-numbered edges, except the last edge. With phase 1 the output changes on odd-numbered edges and the input is captured on even-numbered edges. Edges are counted from 1.
- R3: `cs_n` goes low in the cycle after acceptance. The first `sclk` edge comes `cfg_tcs`+1 cycles later with phase 1, and `cfg_tcs`+1+`cfg_half` cycles later with phase 0.
- R4: `cs_n` returns high exactly `cfg_tcs`+1 system cycles after the last `sclk` edge.
- R5: N = `cfg_wlen` (4 to DATA_W) bits are sent MSB first, taken from `tx_data[N-1:0]`. Higher bits of `tx_data` are ignored.
- R6: With phase 0 the first bit is on the output pad from the cycle `cs_n` falls. With phase 1 the output is 0 until the first edge drives the first bit. After a transfer the output keeps the last bit sent.
- R7: `cfg_d0_out`=1 makes pad 0 the output (`pad_oe`=2'b01) and pad 1 the input. `cfg_d0_out`=0 makes pad 1 the output (`pad_oe`=2'b10) and pad 0 the input. The `pad_o` bit of the input pad is 0, and `pad_i` of the output pad is ignored.
- R8: In the cycle `cs_n` rises, `done` is high for one cycle and `rx_data` takes the N received bits. The first bit received becomes bit N-1 and the upper bits are zero. `rx_data` does not change at any other time.
- R9: `tx_ready` is high and `busy` is low exactly while the channel is idle. A word is accepted only when `tx_valid` and `tx_ready` are both high.
- R10: Changing any configuration input or `tx_data` after acceptance has no effect on the running transfer. The pad direction stays as it was latched until the next acceptance.
- R11: After reset: `cs_n`=1, `tx_ready`=1, `done`=0, `rx_data`=0, pad 0 is the output driving 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the guard-time reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase: 0 = capture on leading edge, 1 = drive on leading edge |
| cfg_half | input | HALF_W | System cycles per serial-clock half period, at least 1 |
| cfg_tcs | input | TCS_W | Chip-select guard field; guard is value+1 cycles |
| cfg_wlen | input | LEN_W | Bits per word, 4 to DATA_W |
| cfg_d0_out | input | 1 | 1: pad 0 drives and pad 1 receives; 0: the reverse |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Channel idle and able to take a word |
| tx_data | input | DATA_W | Transmit word, right aligned |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| rx_data | output | DATA_W | Last received word, right aligned |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| pad_o | output | 2 | Data driven on each pad |
| pad_oe | output | 2 | Output enable per pad; the input pad is tri-stated |
| pad_i | input | 2 | Data seen on each pad |

## Verification
The bench goes after the guard windows. A design that forgot the extra half period in phase 0 would clock the first edge too early, and a design that counted the guard from zero would be one cycle short on both the lead and the trail. The bench also checks the first bit on the pad in both phases, where swapped launch and capture edges would send or receive the whole word shifted by one bit. It covers the 4-bit and 32-bit word lengths, where a wrong alignment shows up as lost or extra bits. Finally, it changes the configuration in the middle of a transfer and puts noise on the unused pad: a design reading live settings or the wrong pad would show a different clock or corrupted receive data.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TRAIL = 2'd3
  } seq_state_e;

  function automatic int wider_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_chan_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int TCS_W  = 4,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [HALF_W-1:0] cfg_half,
  input  logic [TCS_W-1:0]  cfg_tcs,
  input  logic [LEN_W-1:0]  nbits,
  output logic              idle,
  output logic              cs_n,
  output logic              sclk_q,
  output logic              drive_evt,
  output logic              sample_evt,
  output logic              commit,
  output logic              done
);

  localparam int CNT_W  = wider_of(HALF_W, TCS_W) + 1;
  localparam int EDGE_W = LEN_W + 1;

  seq_state_e          st;
  logic [CNT_W-1:0]    cnt;
  logic [EDGE_W-1:0]   edges;
  logic [EDGE_W-1:0]   nxt_edge;
  logic [EDGE_W-1:0]   last_edge;
  logic                cpha_q;
  logic [HALF_W-1:0]   half_q;
  logic [TCS_W-1:0]    tcs_q;
  logic [LEN_W-1:0]    nbits_q;
  logic                tick;
  logic                odd_edge;

  assign idle      = (st == ST_IDLE);
  assign tick      = ((st == ST_LEAD) || (st == ST_SHIFT)) && (cnt == '0);
  assign nxt_edge  = edges + EDGE_W'(1);
  assign last_edge = {nbits_q, 1'b0};
  assign odd_edge  = nxt_edge[0];
  assign commit    = (st == ST_TRAIL) && (cnt == '0);

  // Launch and capture edges per phase setting.
  always_comb begin
    drive_evt  = 1'b0;
    sample_evt = 1'b0;
    if (tick) begin
      if (cpha_q) begin
        drive_evt  = odd_edge;
        sample_evt = !odd_edge;
      end else begin
        drive_evt  = !odd_edge && (nxt_edge != last_edge);
        sample_evt = odd_edge;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      edges   <= '0;
      cs_n    <= 1'b1;
      sclk_q  <= 1'b0;
      cpha_q  <= 1'b0;
      half_q  <= '0;
      tcs_q   <= '0;
      nbits_q <= '0;
      done    <= 1'b0;
    end else begin
      done <= commit;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            cpha_q  <= cfg_cpha;
            half_q  <= cfg_half;
            tcs_q   <= cfg_tcs;
            nbits_q <= nbits;
            sclk_q  <= cfg_cpol;
            cs_n    <= 1'b0;
            edges   <= '0;
            // lead guard: tcs+1 cycles, plus one half period for phase 0
            cnt     <= CNT_W'(cfg_tcs) + (cfg_cpha ? '0 : CNT_W'(cfg_half));
            st      <= ST_LEAD;
          end
        end
        ST_LEAD, ST_SHIFT: begin
          if (cnt == '0) begin
            sclk_q <= ~sclk_q;
            edges  <= nxt_edge;
            if (nxt_edge == last_edge) begin
              cnt <= CNT_W'(tcs_q);
              st  <= ST_TRAIL;
            end else begin
              cnt <= CNT_W'(half_q - HALF_W'(1));
              st  <= ST_SHIFT;
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_TRAIL: begin
          if (cnt == '0) begin
            cs_n <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_cpha,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [LEN_W-1:0]  nbits,
  input  logic              drive_evt,
  input  logic              sample_evt,
  input  logic              sin,
  input  logic              commit,
  output logic              dout,
  output logic [DATA_W-1:0] rx_data
);

  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic [DATA_W-1:0] aligned;
  logic [LEN_W-1:0]  shamt;

  // Move bit N-1 of the word to the top so it leaves first.
  assign shamt   = LEN_W'(DATA_W) - nbits;
  assign aligned = tx_data << shamt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      rx_sh   <= '0;
      dout    <= 1'b0;
      rx_data <= '0;
    end else begin
      if (start) begin
        rx_sh <= '0;
        if (cfg_cpha) begin
          tx_sh <= aligned;
          dout  <= 1'b0;
        end else begin
          tx_sh <= aligned << 1;
          dout  <= aligned[DATA_W-1];
        end
      end else begin
        if (drive_evt) begin
          dout  <= tx_sh[DATA_W-1];
          tx_sh <= tx_sh << 1;
        end
        if (sample_evt) begin
          rx_sh <= {rx_sh[DATA_W-2:0], sin};
        end
      end
      if (commit) begin
        rx_data <= rx_sh;
      end
    end
  end

endmodule

// File: rtl/spi_pad_route.sv
module spi_pad_route #(
  parameter int NPAD = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            cfg_d0_out,
  input  logic            dout,
  input  logic [NPAD-1:0] pad_i,
  output logic [NPAD-1:0] pad_o,
  output logic [NPAD-1:0] pad_oe,
  output logic            sin
);

  logic dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b1;
    end else if (start) begin
      dir_q <= cfg_d0_out;
    end
  end

  for (genvar p = 0; p < NPAD; p++) begin : g_pad
    logic is_out;
    assign is_out    = (p == 0) ? dir_q : !dir_q;
    assign pad_oe[p] = is_out;
    assign pad_o[p]  = is_out & dout;
  end

  assign sin = dir_q ? pad_i[1] : pad_i[0];

endmodule

// File: rtl/spi_master_chan.sv
module spi_master_chan #(
  parameter int DATA_W = 32,
  parameter int HALF_W = 8,
  parameter int TCS_W  = 4,
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [HALF_W-1:0] cfg_half,
  input  logic [TCS_W-1:0]  cfg_tcs,
  input  logic [LEN_W-1:0]  cfg_wlen,
  input  logic              cfg_d0_out,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  output logic              cs_n,
  output logic              sclk,
  output logic [1:0]        pad_o,
  output logic [1:0]        pad_oe,
  input  logic [1:0]        pad_i
);

  logic idle;
  logic start;
  logic sclk_q;
  logic drive_evt;
  logic sample_evt;
  logic commit;
  logic dout;
  logic sin;

  assign tx_ready = idle;
  assign busy     = !idle;
  assign start    = tx_valid && idle;
  assign sclk     = idle ? cfg_cpol : sclk_q;

  spi_seq_ctrl #(
    .HALF_W(HALF_W),
    .TCS_W (TCS_W),
    .LEN_W (LEN_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_cpol  (cfg_cpol),
    .cfg_cpha  (cfg_cpha),
    .cfg_half  (cfg_half),
    .cfg_tcs   (cfg_tcs),
    .nbits     (cfg_wlen),
    .idle      (idle),
    .cs_n      (cs_n),
    .sclk_q    (sclk_q),
    .drive_evt (drive_evt),
    .sample_evt(sample_evt),
    .commit    (commit),
    .done      (done)
  );

  spi_shift_unit #(
    .DATA_W(DATA_W),
    .LEN_W (LEN_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_cpha  (cfg_cpha),
    .tx_data   (tx_data),
    .nbits     (cfg_wlen),
    .drive_evt (drive_evt),
    .sample_evt(sample_evt),
    .sin       (sin),
    .commit    (commit),
    .dout      (dout),
    .rx_data   (rx_data)
  );

  spi_pad_route #(
    .NPAD(2)
  ) u_pad (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_d0_out(cfg_d0_out),
    .dout      (dout),
    .pad_i     (pad_i),
    .pad_o     (pad_o),
    .pad_oe    (pad_oe),
    .sin       (sin)
  );

endmodule

// File: rtl/spi_chan_chk.sv
module spi_chan_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_ready,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rx_data,
  input logic              cs_n,
  input logic              sclk,
  input logic [1:0]        pad_oe
);

  p_busy_cs_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n);

  p_ready_cs_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> cs_n);

  p_lead_no_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $stable(sclk));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_with_cs_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n));

  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rx_data));

  p_one_driver_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pad_oe) == 1);

endmodule

bind spi_master_chan spi_chan_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tx_ready(tx_ready),
  .busy    (busy),
  .done    (done),
  .rx_data (rx_data),
  .cs_n    (cs_n),
  .sclk    (sclk),
  .pad_oe  (pad_oe)
);

// File: tb/spi_master_chan_tb_top.sv
module spi_master_chan_tb_top;

  localparam int DW = 32;
  localparam int HW = 8;
  localparam int TW = 4;
  localparam int LW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_cpol = 1'b0;
  logic          cfg_cpha = 1'b0;
  logic [HW-1:0] cfg_half = 8'd1;
  logic [TW-1:0] cfg_tcs = '0;
  logic [LW-1:0] cfg_wlen = 6'd8;
  logic          cfg_d0_out = 1'b1;
  logic          tx_valid = 1'b0;
  logic          tx_ready;
  logic [DW-1:0] tx_data = '0;
  logic          busy;
  logic          done;
  logic [DW-1:0] rx_data;
  logic          cs_n;
  logic          sclk;
  logic [1:0]    pad_o;
  logic [1:0]    pad_oe;
  logic [1:0]    pad_i = 2'b00;

  always #4 clk = ~clk;

  spi_master_chan dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_half(cfg_half), .cfg_tcs(cfg_tcs), .cfg_wlen(cfg_wlen),
    .cfg_d0_out(cfg_d0_out), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .busy(busy), .done(done), .rx_data(rx_data),
    .cs_n(cs_n), .sclk(sclk), .pad_o(pad_o), .pad_oe(pad_oe), .pad_i(pad_i)
  );

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // model state carried between transfers
  bit            m_dout = 1'b0;
  bit            m_dir = 1'b1;
  logic [DW-1:0] m_rx = '0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pad_cmp(input bit dv);
    chk("R7 pad_oe", 32'(pad_oe), m_dir ? 32'd1 : 32'd2);
    chk("R7 pad_o", 32'(pad_o), m_dir ? 32'({1'b0, dv}) : 32'({dv, 1'b0}));
  endtask

  task automatic idle_cmp();
    chk("R9 cs_n idle", 32'(cs_n), 32'd1);
    chk("R1 sclk idle level", 32'(sclk), 32'(cfg_cpol));
    chk("R9 tx_ready idle", 32'(tx_ready), 32'd1);
    chk("R9 busy idle", 32'(busy), 32'd0);
    chk("R8 done idle", 32'(done), 32'd0);
    chk("R8 rx_data hold", rx_data, m_rx);
    chk("R6 dout hold", 32'(m_dir ? pad_o[0] : pad_o[1]), 32'(m_dout));
    pad_cmp(m_dout);
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      idle_cmp();
    end
  endtask

  task automatic run_xfer(input bit cpol, input bit cpha, input int half, input int tcs,
                          input int n, input bit d0, input logic [DW-1:0] txw,
                          input logic [DW-1:0] pat, input bit flip);
    int lead, tend, e, k, d, j;
    bit exp_dout;
    logic [DW-1:0] mask;
    mask = (n >= DW) ? '1 : ((32'd1 << n) - 32'd1);
    @(negedge clk);
    idle_cmp();
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_half = HW'(half); cfg_tcs = TW'(tcs);
    cfg_wlen = LW'(n); cfg_d0_out = d0; tx_data = txw; tx_valid = 1'b1;
    pad_i[d0 ? 1 : 0] = pat[n-1];
    pad_i[d0 ? 0 : 1] = 1'b1;
    m_dir = d0;
    lead = tcs + 1 + (cpha ? 0 : half);
    tend = lead + (2 * n - 1) * half + tcs + 1;
    exp_dout = 1'b0;
    for (int t = 0; t <= tend; t++) begin
      @(negedge clk);
      tx_valid = 1'b0;
      if (t < lead) e = 0;
      else begin
        k = (t - lead) / half + 1;
        e = (k > 2 * n) ? 2 * n : k;
      end
      if (cpha) begin
        d = (e + 1) / 2;
        exp_dout = (d == 0) ? 1'b0 : txw[n-d];
      end else begin
        d = e / 2;
        if (d > n - 1) d = n - 1;
        exp_dout = txw[n-1-d];
      end
      if (t < tend) begin
        chk("R3 R4 cs_n low through guards", 32'(cs_n), 32'd0);
        if (t < lead) chk("R3 lead window sclk", 32'(sclk), 32'(cpol));
        else chk("R1 R2 sclk edges", 32'(sclk), 32'(cpol ^ e[0]));
        chk("R9 tx_ready busy", 32'(tx_ready), 32'd0);
        chk("R9 busy flag", 32'(busy), 32'd1);
        chk("R8 done quiet", 32'(done), 32'd0);
        chk("R8 rx_data stable", rx_data, m_rx);
      end else begin
        chk("R4 cs_n trail release", 32'(cs_n), 32'd1);
        chk("R1 sclk back to idle", 32'(sclk), 32'(cfg_cpol));
        chk("R9 tx_ready after", 32'(tx_ready), 32'd1);
        chk("R8 done pulse", 32'(done), 32'd1);
        chk("R8 rx_data word", rx_data, pat & mask);
      end
      if (t == 0) chk("R6 first bit placement", 32'(d0 ? pad_o[0] : pad_o[1]), 32'(exp_dout));
      else chk("R2 R5 dout bit", 32'(d0 ? pad_o[0] : pad_o[1]), 32'(exp_dout));
      pad_cmp(exp_dout);
      // slave drives the bit for the next capture edge; noise elsewhere
      j = cpha ? e / 2 : (e + 1) / 2;
      if (j > n - 1) j = n - 1;
      pad_i[d0 ? 1 : 0] = pat[n-1-j];
      pad_i[d0 ? 0 : 1] = ~t[0];
      if (flip && t == 2) begin
        // R10: live configuration changes must not disturb this transfer
        cfg_cpol = ~cfg_cpol; cfg_cpha = ~cfg_cpha; cfg_half = 8'd7;
        cfg_tcs = 4'd9; cfg_wlen = 6'd5; cfg_d0_out = ~cfg_d0_out;
        tx_data = ~tx_data;
      end
    end
    m_rx = pat & mask;
    m_dout = exp_dout;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      miscompares++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state, observed while reset is held
    chk("R11 cs_n in reset", 32'(cs_n), 32'd1);
    chk("R11 rx_data in reset", rx_data, 32'd0);
    chk("R11 done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    idle_cycles(3);
    chk("R11 pad_oe after reset", 32'(pad_oe), 32'd1);

    // mode 0, fastest clock, shortest guard
    run_xfer(1'b0, 1'b0, 1, 0, 8, 1'b1, 32'h0000_00A5, 32'h0000_003C, 1'b0);
    idle_cycles(2);
    // mode 1, pad 1 drives
    run_xfer(1'b0, 1'b1, 2, 1, 8, 1'b0, 32'h0000_0096, 32'h0000_00E1, 1'b0);
    idle_cycles(2);
    // mode 2, minimum word length, upper tx bits are noise (R5)
    run_xfer(1'b1, 1'b0, 3, 2, 4, 1'b1, 32'hFFFF_FFF9, 32'h0000_0006, 1'b0);
    idle_cycles(2);
    // mode 3, maximum word length
    run_xfer(1'b1, 1'b1, 1, 3, 32, 1'b1, 32'hC3A5_0F81, 32'h5AF0_3C96, 1'b0);
    idle_cycles(1);
    // R10: configuration changed mid-transfer
    run_xfer(1'b0, 1'b1, 2, 2, 16, 1'b0, 32'hABCD_1234, 32'h0000_8001, 1'b1);
    idle_cycles(2);
    // back-to-back words, direction swap between them
    run_xfer(1'b1, 1'b0, 2, 0, 12, 1'b1, 32'h0000_0F0F, 32'h0000_0A5A, 1'b0);
    run_xfer(1'b0, 1'b0, 4, 15, 12, 1'b0, 32'h0000_0801, 32'h0000_07FE, 1'b0);
    idle_cycles(3);
    report();
  end

endmodule